// File: doc/BRIEF.md
# Event Recorder Status Register

This block holds the status word of a three-channel event recorder. Each channel delivers a one-cycle event strobe that is already synchronous to the block clock. Events are not posted to the visible flags when they arrive. Each channel first collects them in a hidden per-second pending bit. On every one-second tick, the pending bit is copied into the channel's visible flag and then cleared. A software reader therefore sees, at whole-second granularity, which channels were active.

The status word has two more flags. A sticky flag records that the general-purpose register bank was cleared asynchronously. That indication arrives unsynchronised, passes through a two-flop synchroniser and then an edge detector. A summary wakeup flag drives the `irq` output. It sets whenever an enabled source receives a hardware set. All flags are cleared by writing one to them over a simple single-register write port. The status word can be read at all times on `bus_rdata`.

Top module: `evt_status_reg`

## Requirements
- R1: Channel i flag is status bit i (bits 2:0), the general-purpose clear flag is bit 3 and the wakeup flag is bit 31. Bits 30:4 always read 0, and writing ones to them changes nothing.
- R2: A channel flag becomes 1 on the clock edge that ends a `sec_tick` cycle, but only if that channel strobed at least once from the previous tick cycle (inclusive) up to this tick cycle (exclusive). Without an event the flag keeps its value.
- R3: A strobe in the same cycle as `sec_tick` is not posted at that tick. It is posted at the following tick.
- R4: Writing 1 to bit 0, 1, 2, 3 or 31 clears that flag on the next edge. Writing 0 leaves it unchanged.
- R5: When a hardware set and a write-one clear of the same flag fall in one cycle, the flag ends up 1.
- R6: A rising edge on `gp_clr_async` that is stable before edge k sets bit 3 at edge k+2, so bit 3 is visible after the third edge. A level that stays high does not set the flag again once it has been cleared.
- R7: The wakeup flag sets on the same edge as a hardware set of any source whose enable is 1. `wake_en` bit i enables channel i and bit 3 enables the general-purpose flag. Disabled sources never set it, and a write cannot set it.
- R8: `irq` always equals status bit 31.
- R9: Reset clears every flag and every pending bit. A tick with no events after reset posts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_strobe | input | 3 | Per-channel event strobes, synchronous |
| sec_tick | input | 1 | One-cycle pulse marking the end of a second |
| gp_clr_async | input | 1 | Asynchronous indication that the general-purpose bank was cleared |
| wake_en | input | 4 | Wakeup enables: bits 2:0 for channels, bit 3 for the general-purpose flag |
| bus_wr | input | 1 | Write strobe for the status word |
| bus_wdata | input | 32 | Write data, one bit per flag to clear |
| bus_rdata | output | 32 | Current status word |
| irq | output | 1 | Interrupt/wakeup request |

## Verification
Channel flags and the wakeup flag are due one edge after the tick cycle or write cycle that causes them. The general-purpose flag is due three edges after its input rises. The bench drives every input on the falling edge and advances its expected-value model once per rising edge. It then compares `bus_rdata` and `irq` on the next falling edge, so every comparison falls in the cycle where the result is due. Directed sequences also check the cycles just before a result is due, which shows that it does not arrive early.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;

  localparam int unsigned DEF_STAT_W = 32;
  localparam int unsigned DEF_NUM_CH = 3;

  // next value of a sticky flag: hardware set beats software clear
  function automatic logic sticky_next(input logic cur, input logic hw_set,
                                       input logic sw_clr);
    if (hw_set) return 1'b1;
    if (sw_clr) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/evt_sticky_flag.sv
module evt_sticky_flag
  import evt_status_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hw_set,
  input  logic sw_clr,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= sticky_next(flag, hw_set, sw_clr);
  end

  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    hw_set |=> flag);

  p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
    (sw_clr && !hw_set) |=> !flag);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!sw_clr && !hw_set) |=> $stable(flag));

endmodule

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);

  localparam int unsigned LAST = STAGES;

  logic [LAST:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[LAST-1:0], async_in};
  end

  assign rise = shreg[LAST-1] & ~shreg[LAST];

  // an edge produces a single-cycle pulse (R6)
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/evt_chan_accum.sv
module evt_chan_accum (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic tick,
  input  logic sw_clr,
  output logic flag,
  output logic post
);

  logic pend;

  always_ff @(posedge clk) begin
    if (rst)       pend <= 1'b0;
    else if (tick) pend <= strobe;
    else           pend <= pend | strobe;
  end

  assign post = tick & pend;

  evt_sticky_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .hw_set (post),
    .sw_clr (sw_clr),
    .flag   (flag)
  );

  p_defer_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && strobe) |=> pend);

  p_drain_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !strobe) |=> !pend);

  p_keep_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && pend) |=> pend);

  p_post_only_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(tick));

endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
  import evt_status_pkg::*;
#(
  parameter int unsigned NUM_CH      = DEF_NUM_CH,
  parameter int unsigned STAT_W      = DEF_STAT_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] evt_strobe,
  input  logic              sec_tick,
  input  logic              gp_clr_async,
  input  logic [NUM_CH:0]   wake_en,
  input  logic              bus_wr,
  input  logic [STAT_W-1:0] bus_wdata,
  output logic [STAT_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int unsigned GP_BIT   = NUM_CH;
  localparam int unsigned WAKE_BIT = STAT_W - 1;
  localparam int unsigned RSV_W    = STAT_W - NUM_CH - 2;

  logic [NUM_CH-1:0] ch_flag;
  logic [NUM_CH-1:0] ch_post;
  logic              gp_rise;
  logic              gp_flag;
  logic              wake_flag;
  logic              wake_set;
  logic              unused_rsv_bits;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
      evt_chan_accum u_ch (
        .clk    (clk),
        .rst    (rst),
        .strobe (evt_strobe[gi]),
        .tick   (sec_tick),
        .sw_clr (bus_wr & bus_wdata[gi]),
        .flag   (ch_flag[gi]),
        .post   (ch_post[gi])
      );
    end
  endgenerate

  evt_sync_edge #(.STAGES(SYNC_STAGES)) u_gp_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (gp_clr_async),
    .rise     (gp_rise)
  );

  evt_sticky_flag u_gp (
    .clk    (clk),
    .rst    (rst),
    .hw_set (gp_rise),
    .sw_clr (bus_wr & bus_wdata[GP_BIT]),
    .flag   (gp_flag)
  );

  assign wake_set = (|(ch_post & wake_en[NUM_CH-1:0])) | (gp_rise & wake_en[NUM_CH]);

  evt_sticky_flag u_wake (
    .clk    (clk),
    .rst    (rst),
    .hw_set (wake_set),
    .sw_clr (bus_wr & bus_wdata[WAKE_BIT]),
    .flag   (wake_flag)
  );

  assign unused_rsv_bits = ^bus_wdata[WAKE_BIT-1:GP_BIT+1];

  assign bus_rdata = {wake_flag, {RSV_W{1'b0}}, gp_flag, ch_flag};
  assign irq       = wake_flag;

  // wakeup only rises alongside an enabled source flag being set (R7)
  p_wake_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (|(bus_rdata[GP_BIT:0] & $past(wake_en))));

  // bank-clear flag only rises after a synchronised edge (R6)
  p_gp_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(gp_flag) |-> $past(gp_rise));

endmodule

// File: tb/test_evt_status_reg.sv
`timescale 1ns/1ps
module test_evt_status_reg;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  evt_strobe;
  logic        sec_tick;
  logic        gp_clr_async;
  logic [3:0]  wake_en;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  evt_status_reg i_evt_status_reg (
    .clk          (clk),
    .rst          (rst),
    .evt_strobe   (evt_strobe),
    .sec_tick     (sec_tick),
    .gp_clr_async (gp_clr_async),
    .wake_en      (wake_en),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .irq          (irq)
  );

  // expected-value model state
  logic [2:0] m_pend, m_flag;
  logic       m_s1, m_s2, m_s3, m_gp, m_wake;

  function automatic logic [31:0] model_word(input logic w, input logic g,
                                             input logic [2:0] f);
    return {w, 27'd0, g, f};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_total++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_pend = '0; m_flag = '0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_gp = 0; m_wake = 0;
  endtask

  task automatic step(input logic [2:0] evt, input logic tick, input logic gp,
                      input logic wr, input logic [31:0] wd, input string tag);
    logic [2:0] set_ch, n_pend, n_flag;
    logic rise, n_gp, n_wake, any;
    evt_strobe = evt; sec_tick = tick; gp_clr_async = gp; bus_wr = wr; bus_wdata = wd;
    set_ch = tick ? m_pend : 3'b000;
    n_pend = tick ? evt : (m_pend | evt);
    for (int i = 0; i < 3; i++)
      n_flag[i] = set_ch[i] ? 1'b1 : ((wr && wd[i]) ? 1'b0 : m_flag[i]);
    rise = m_s2 & ~m_s3;
    n_gp = rise ? 1'b1 : ((wr && wd[3]) ? 1'b0 : m_gp);
    any = (|(set_ch & wake_en[2:0])) | (rise & wake_en[3]);
    n_wake = any ? 1'b1 : ((wr && wd[31]) ? 1'b0 : m_wake);
    @(posedge clk);
    m_pend = n_pend; m_flag = n_flag; m_s3 = m_s2; m_s2 = m_s1; m_s1 = gp;
    m_gp = n_gp; m_wake = n_wake;
    @(negedge clk);
    chk({tag, " model word"}, bus_rdata, model_word(m_wake, m_gp, m_flag));
    chk({tag, " R8 irq"}, {31'd0, irq}, {31'd0, m_wake});
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(3'b000, 1'b0, gp_clr_async, 1'b0, 32'd0, tag);
  endtask

  task automatic clear_all();
    step(3'b000, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, "R4 clear all");
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; evt_strobe = '0; sec_tick = 0; gp_clr_async = 0;
    wake_en = 4'hF; bus_wr = 0; bus_wdata = '0;
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset word", bus_rdata, 32'd0);
    chk("R9 reset irq", {31'd0, irq}, 32'd0);

    // R9: tick with nothing pending posts nothing
    step(3'b000, 1'b1, 1'b0, 1'b0, 32'd0, "R9 empty tick");
    chk("R9 empty tick word", bus_rdata, 32'd0);

    // R2: event then tick posts channel 0 and wakes
    step(3'b001, 1'b0, 1'b0, 1'b0, 32'd0, "R2 event");
    chk("R2 not early", bus_rdata, 32'd0);
    idle(2, "R2 wait");
    step(3'b000, 1'b1, 1'b0, 1'b0, 32'd0, "R2 tick");
    chk("R2 posted", bus_rdata, 32'h8000_0001);

    // R3: event on tick cycle waits for the next tick
    step(3'b010, 1'b1, 1'b0, 1'b0, 32'd0, "R3 same cycle");
    chk("R3 deferred", bus_rdata & 32'h2, 32'h0);
    idle(1, "R3 wait");
    step(3'b000, 1'b1, 1'b0, 1'b0, 32'd0, "R3 next tick");
    chk("R3 posted next", bus_rdata, 32'h8000_0003);

    // R4: write zero no effect, write one clears
    step(3'b000, 1'b0, 1'b0, 1'b1, 32'h0, "R4 write zero");
    chk("R4 write zero", bus_rdata, 32'h8000_0003);
    step(3'b000, 1'b0, 1'b0, 1'b1, 32'h1, "R4 clear ch0");
    chk("R4 clear ch0", bus_rdata, 32'h8000_0002);
    step(3'b000, 1'b0, 1'b0, 1'b1, 32'h8000_0000, "R4 clear wake");
    chk("R4 clear wake", bus_rdata, 32'h0000_0002);

    // R1: reserved writes ignored, read zero
    step(3'b000, 1'b0, 1'b0, 1'b1, 32'h7FFF_FFF0, "R1 reserved");
    chk("R1 reserved", bus_rdata, 32'h0000_0002);

    // R5: set and clear collide, set wins
    step(3'b100, 1'b0, 1'b0, 1'b0, 32'd0, "R5 event");
    step(3'b000, 1'b1, 1'b0, 1'b1, 32'h8000_0004, "R5 collide");
    chk("R5 set wins", bus_rdata, 32'h8000_0006);
    clear_all();
    chk("R4 all cleared", bus_rdata, 32'd0);

    // R6: bank-clear edge lands on the third edge
    step(3'b000, 1'b0, 1'b1, 1'b0, 32'd0, "R6 edge1");
    chk("R6 edge1", bus_rdata, 32'd0);
    step(3'b000, 1'b0, 1'b1, 1'b0, 32'd0, "R6 edge2");
    chk("R6 edge2", bus_rdata, 32'd0);
    step(3'b000, 1'b0, 1'b1, 1'b0, 32'd0, "R6 edge3");
    chk("R6 edge3", bus_rdata, 32'h8000_0008);
    step(3'b000, 1'b0, 1'b1, 1'b1, 32'h8000_0008, "R6 clear");
    idle(4, "R6 held level");
    chk("R6 no reset by level", bus_rdata, 32'd0);
    step(3'b000, 1'b0, 1'b0, 1'b0, 32'd0, "R6 drop");

    // R7: disabled sources do not wake
    wake_en = 4'b0000;
    step(3'b001, 1'b0, 1'b0, 1'b0, 32'd0, "R7 event");
    step(3'b000, 1'b1, 1'b0, 1'b0, 32'd0, "R7 tick off");
    chk("R7 disabled", bus_rdata, 32'h0000_0001);
    chk("R8 irq low", {31'd0, irq}, 32'd0);
    wake_en = 4'b0010;
    step(3'b011, 1'b0, 1'b0, 1'b0, 32'd0, "R7 events");
    step(3'b000, 1'b1, 1'b0, 1'b0, 32'd0, "R7 tick on");
    chk("R7 enabled ch1", bus_rdata, 32'h8000_0003);
    chk("R8 irq high", {31'd0, irq}, 32'd1);
    step(3'b000, 1'b0, 1'b0, 1'b1, 32'h0000_0000, "R7 write cannot set");
    clear_all();

    // random traffic against the model
    void'($urandom(32'd20240611));
    wake_en = 4'hF;
    for (int c = 0; c < 3000; c++) begin
      logic [2:0] e;
      logic t, g, w;
      logic [31:0] d;
      for (int b = 0; b < 3; b++) e[b] = ($urandom % 5) == 0;
      t = ($urandom % 7) == 0;
      g = (($urandom % 13) == 0) ? ~gp_clr_async : gp_clr_async;
      w = ($urandom % 6) == 0;
      d = $urandom;
      if (($urandom % 50) == 0) wake_en = 4'($urandom);
      step(e, t, g, w, d, "R2 R3 R4 R5 R6 R7 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule